// File: doc/BRIEF.md
# Coherent Store Queue with Write Ordering Fence

This block sits between a core's store port and its private data cache in a MESI-coherent system. A store that can commit at once goes straight to the cache. That is the case when its line is owned (Exclusive or Modified), no fence is pending and no earlier buffered store targets the same line. Any other store is parked in a small queue and the core moves on. A store that needs ownership sends its coherence request in the cycle it is accepted. The parked data is written to the cache only after the matching acknowledgement has come back, and the line then becomes Modified.

Loads look in the queue before they use the cache, so a core always reads its own latest store. A fence input tags every entry in the queue. While any tagged entry remains, every new store must join the queue, even one that hits an owned line. This keeps all stores issued before the fence visible ahead of every store issued after it. Entries leave the queue strictly in the order they were allocated. When the queue is full, the store port stalls.

Line states on `st_line_state` are encoded as 2'b00 Invalid, 2'b01 Shared, 2'b10 Exclusive and 2'b11 Modified. A cache write (`cw_en`) always leaves the written line Modified.

Top module: `store_buffer`

## Requirements
- R1: An accepted store whose line is Invalid (00) or Shared (01) is queued. In the same cycle it raises `req_valid` with `req_addr` equal to the store address, and `req_kind` set to 1 (read-invalidate) for Invalid or 0 (invalidate) for Shared. No request is raised in any other cycle.
- R2: A queued store that waits for ownership is never written to the cache before `rsp_valid` arrives with its address. One response clears every queued entry with that address. The earliest write comes in the cycle after the response.
- R3: `ld_data` returns the data of the youngest queued entry whose address equals `ld_addr`, with `ld_fwd` high. With no match, `ld_fwd` is low and `ld_data` equals `ld_cache_data`.
- R4: A fence pulse on `wbar` tags every entry in the queue. A store accepted in the same cycle as the fence counts as before the fence and is tagged too.
- R5: While any tagged entry remains, an accepted store to an Exclusive or Modified line is queued and does not write the cache in that cycle.
- R6: Queued entries are written to the cache strictly in allocation order. A head entry still waiting for ownership blocks all later entries, even those already acknowledged. Tagged entries therefore always drain before untagged ones.
- R7: A store to an Exclusive or Modified line commits directly in the same cycle if no tagged entry exists and no queued entry has its address. It raises `cw_en` with its own address and data, even while unrelated untagged entries are still waiting. A direct write takes the cache port, and the head drain waits one cycle.
- R8: With DEPTH entries queued, `st_ready` is low. A store presented while the queue is full has no effect: no request and no cache write. `st_ready` returns in the cycle after an entry drains.
- R9: A fence while the queue is empty has no effect. A following store to an owned line still commits directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Store request from the core |
| st_addr | input | AW | Store line address |
| st_data | input | DW | Store data |
| st_line_state | input | 2 | Local cache state of the store's line (00 I, 01 S, 10 E, 11 M) |
| st_ready | output | 1 | Store accepted this cycle when high |
| wbar | input | 1 | Write-ordering fence pulse |
| ld_addr | input | AW | Load address |
| ld_cache_data | input | DW | Data the cache returns for `ld_addr` |
| ld_data | output | DW | Load result after queue forwarding |
| ld_fwd | output | 1 | Load result came from the queue |
| cw_en | output | 1 | Cache write; the line becomes Modified |
| cw_addr | output | AW | Cache write address |
| cw_data | output | DW | Cache write data |
| req_valid | output | 1 | Coherence request |
| req_kind | output | 1 | 1 read-invalidate, 0 invalidate |
| req_addr | output | AW | Coherence request address |
| rsp_valid | input | 1 | Ownership granted (response and invalidate acknowledgement) |
| rsp_addr | input | AW | Address of the granted line |

## Verification
Some rules are checked on every cycle. These are: the request a store raises for an Invalid or Shared line; that requests come only with accepted stores; that the occupancy grows whenever a store arrives while tagged entries exist; that a full queue stays full until a write; and that a fence on an empty queue leaves nothing tagged. Other behaviour only shows up over the bench's scenarios. This covers the exact sequence of cache writes when acknowledgements come out of order, youngest-entry forwarding with duplicate addresses, and the reordering of an owned store past an untagged miss that a fence then forbids.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10,
    LS_MOD = 2'b11
  } line_st_e;

  typedef enum logic {
    RQ_INV   = 1'b0,
    RQ_RDINV = 1'b1
  } req_kind_e;
endpackage

// File: rtl/sb_rst_sync.sv
module sb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sb_queue.sv
module sb_queue #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [AW-1:0]                 push_addr,
  input  logic [DW-1:0]                 push_data,
  input  logic                          push_wait,
  input  logic                          pop,
  input  logic                          fence,
  input  logic                          ack_valid,
  input  logic [AW-1:0]                 ack_addr,
  output logic [DEPTH-1:0]              vld,
  output logic [DEPTH-1:0]              mrk,
  output logic [DEPTH-1:0]              wt,
  output logic [DEPTH-1:0][AW-1:0]      adr,
  output logic [DEPTH-1:0][DW-1:0]      dat,
  output logic [CW-1:0]                 cnt
);
  logic [DEPTH-1:0]         v_q, v_n, m_q, m_n, w_q, w_n, w_ack;
  logic [DEPTH-1:0][AW-1:0] a_q, a_n;
  logic [DEPTH-1:0][DW-1:0] d_q, d_n;
  logic [CW-1:0]            cnt_q, cnt_n, tail;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      w_ack[i] = w_q[i] & ~(ack_valid & v_q[i] & (a_q[i] == ack_addr));

    for (int i = 0; i < DEPTH; i++) begin
      if (pop) begin
        if (i < DEPTH - 1) begin
          v_n[i] = v_q[i+1];
          m_n[i] = m_q[i+1];
          w_n[i] = w_ack[i+1];
          a_n[i] = a_q[i+1];
          d_n[i] = d_q[i+1];
        end else begin
          v_n[i] = 1'b0;
          m_n[i] = 1'b0;
          w_n[i] = 1'b0;
          a_n[i] = a_q[i];
          d_n[i] = d_q[i];
        end
      end else begin
        v_n[i] = v_q[i];
        m_n[i] = m_q[i];
        w_n[i] = w_ack[i];
        a_n[i] = a_q[i];
        d_n[i] = d_q[i];
      end
    end

    tail = cnt_q - CW'(pop);
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (CW'(i) == tail)) begin
        v_n[i] = 1'b1;
        m_n[i] = 1'b0;
        w_n[i] = push_wait;
        a_n[i] = push_addr;
        d_n[i] = push_data;
      end
    end

    if (fence) m_n = m_n | v_n;

    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      m_q   <= '0;
      w_q   <= '0;
      cnt_q <= '0;
    end else begin
      v_q   <= v_n;
      m_q   <= m_n;
      w_q   <= w_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push || pop) begin
      a_q <= a_n;
      d_q <= d_n;
    end
  end

  assign vld = v_q;
  assign mrk = m_q;
  assign wt  = w_q;
  assign adr = a_q;
  assign dat = d_q;
  assign cnt = cnt_q;
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0]         vld,
  input  logic [DEPTH-1:0][AW-1:0] adr,
  input  logic [DEPTH-1:0][DW-1:0] dat,
  input  logic [AW-1:0]            ld_addr,
  input  logic [AW-1:0]            st_addr,
  output logic                     ld_hit,
  output logic [DW-1:0]            ld_hit_data,
  output logic                     st_hit
);
  logic [DEPTH-1:0] ld_m, st_m;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign ld_m[g] = vld[g] & (adr[g] == ld_addr);
    assign st_m[g] = vld[g] & (adr[g] == st_addr);
  end

  // Higher slot index holds a younger store: the last match wins.
  always_comb begin
    ld_hit_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ld_m[i]) ld_hit_data = dat[i];
  end

  assign ld_hit = |ld_m;
  assign st_hit = |st_m;
endmodule

// File: rtl/store_buffer.sv
module store_buffer
  import sb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic [1:0]    st_line_state,
  output logic          st_ready,
  input  logic          wbar,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_cache_data,
  output logic [DW-1:0] ld_data,
  output logic          ld_fwd,
  output logic          cw_en,
  output logic [AW-1:0] cw_addr,
  output logic [DW-1:0] cw_data,
  output logic          req_valid,
  output logic          req_kind,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_addr
);
  localparam int CW = $clog2(DEPTH + 1);

  logic                     rst_n_s;
  logic [DEPTH-1:0]         vld, mrk, wt;
  logic [DEPTH-1:0][AW-1:0] adr;
  logic [DEPTH-1:0][DW-1:0] dat;
  logic [CW-1:0]            cnt;
  logic                     any_mark, st_hit, ld_hit;
  logic [DW-1:0]            ld_hit_data;
  logic                     st_fire, owned, direct, push, head_go;
  line_st_e                 st_state;

  sb_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .rst_n_sync(rst_n_s));

  assign st_state = line_st_e'(st_line_state);
  assign owned    = (st_state == LS_EXC) || (st_state == LS_MOD);
  assign any_mark = |(mrk & vld);
  assign st_ready = (cnt != CW'(DEPTH));
  assign st_fire  = st_valid & st_ready;
  assign direct   = st_fire & owned & ~any_mark & ~st_hit;
  assign push     = st_fire & ~direct;
  assign head_go  = vld[0] & ~wt[0] & ~direct;

  sb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (push),
    .push_addr (st_addr),
    .push_data (st_data),
    .push_wait (~owned),
    .pop       (head_go),
    .fence     (wbar),
    .ack_valid (rsp_valid),
    .ack_addr  (rsp_addr),
    .vld       (vld),
    .mrk       (mrk),
    .wt        (wt),
    .adr       (adr),
    .dat       (dat),
    .cnt       (cnt)
  );

  sb_lookup #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_lookup (
    .vld         (vld),
    .adr         (adr),
    .dat         (dat),
    .ld_addr     (ld_addr),
    .st_addr     (st_addr),
    .ld_hit      (ld_hit),
    .ld_hit_data (ld_hit_data),
    .st_hit      (st_hit)
  );

  assign cw_en   = direct | head_go;
  assign cw_addr = direct ? st_addr : adr[0];
  assign cw_data = direct ? st_data : dat[0];

  assign req_valid = push & ~owned;
  assign req_kind  = (st_state == LS_INV) ? RQ_RDINV : RQ_INV;
  assign req_addr  = st_addr;

  assign ld_fwd  = ld_hit;
  assign ld_data = ld_hit ? ld_hit_data : ld_cache_data;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          st_valid,
  input logic          st_ready,
  input logic [1:0]    st_line_state,
  input logic [AW-1:0] st_addr,
  input logic          req_valid,
  input logic          req_kind,
  input logic [AW-1:0] req_addr,
  input logic          wbar,
  input logic          cw_en,
  input logic [CW-1:0] cnt,
  input logic          any_mark
);
  AST_REQ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_line_state == 2'b00) |-> (req_valid && req_kind && req_addr == st_addr)); // R1
  AST_REQ_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_line_state == 2'b01) |-> (req_valid && !req_kind && req_addr == st_addr)); // R1
  AST_REQ_ONLY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (st_valid && st_ready)); // R1
  AST_FENCE_QUEUES: assert property (@(posedge clk) disable iff (!rst_n)
    (any_mark && st_valid && st_ready) |=> (cnt == $past(cnt) + CW'(1) - CW'($past(cw_en)))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !cw_en) |=> (cnt == CW'(DEPTH))); // R8
  AST_EMPTY_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wbar && cnt == '0 && !(st_valid && st_ready)) |=> !any_mark); // R9
endmodule

bind store_buffer sb_checker #(.AW(AW), .DEPTH(DEPTH)) u_sb_checker (
  .clk           (clk),
  .rst_n         (rst_n_s),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .st_line_state (st_line_state),
  .st_addr       (st_addr),
  .req_valid     (req_valid),
  .req_kind      (req_kind),
  .req_addr      (req_addr),
  .wbar          (wbar),
  .cw_en         (cw_en),
  .cnt           (cnt),
  .any_mark      (any_mark)
);

// File: tb/tb_store_buffer.sv
module tb_store_buffer;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  typedef struct {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string         tag;
  } wr_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid, wbar, rsp_valid;
  logic [AW-1:0] st_addr, ld_addr, rsp_addr;
  logic [DW-1:0] st_data, ld_cache_data;
  logic [1:0]    st_line_state;
  logic          st_ready, ld_fwd, cw_en, req_valid, req_kind;
  logic [DW-1:0] ld_data, cw_data;
  logic [AW-1:0] cw_addr, req_addr;

  int  checks = 0;
  int  errors = 0;
  wr_t exp_q[$];

  always #5 clk = ~clk;

  store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    wr_t w;
    w.addr = a; w.data = d; w.tag = tag;
    exp_q.push_back(w);
  endtask

  // Monitor: every cache write is compared against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && cw_en) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected cache write: actual %h expected none", cw_addr);
      end else begin
        wr_t w;
        w = exp_q.pop_front();
        chk(cw_addr == w.addr, w.tag, "write address", DW'(cw_addr), DW'(w.addr));
        chk(cw_data == w.data, w.tag, "write data", cw_data, w.data);
      end
    end
  end

  // Called at posedge+1; returns at the next posedge+1.
  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s,
                       input bit exp_direct, input bit exp_req, input bit exp_kind, input string tag);
    if (exp_direct) expect_wr(a, d, tag);
    st_valid = 1'b1; st_addr = a; st_data = d; st_line_state = s;
    #2;
    chk(st_ready == 1'b1, tag, "st_ready", DW'(st_ready), 1);
    chk(req_valid == exp_req, tag, "req_valid", DW'(req_valid), DW'(exp_req));
    if (exp_req) begin
      chk(req_kind == exp_kind, tag, "req_kind", DW'(req_kind), DW'(exp_kind));
      chk(req_addr == a, tag, "req_addr", DW'(req_addr), DW'(a));
    end
    if (exp_direct) chk(cw_en == 1'b1, tag, "direct cw_en", DW'(cw_en), 1);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic respond(input logic [AW-1:0] a);
    rsp_valid = 1'b1; rsp_addr = a;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic fence();
    wbar = 1'b1;
    @(posedge clk); #1;
    wbar = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input bit exp_fwd, input logic [DW-1:0] exp_d, input string tag);
    ld_addr = a; ld_cache_data = 32'hC000_0000 | DW'(a);
    #1;
    chk(ld_fwd == exp_fwd, tag, "ld_fwd", DW'(ld_fwd), DW'(exp_fwd));
    chk(ld_data == (exp_fwd ? exp_d : ld_cache_data), tag, "ld_data", ld_data,
        exp_fwd ? exp_d : ld_cache_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; wbar = 1'b0; rsp_valid = 1'b0;
    st_addr = '0; st_data = '0; st_line_state = 2'b00; ld_addr = '0;
    ld_cache_data = '0; rsp_addr = '0;
    #25 rst_n = 1'b1;
    idle(4);

    // Reset state
    chk(st_ready == 1'b1, "R8", "reset st_ready", DW'(st_ready), 1);
    chk(cw_en == 1'b0, "R7", "reset cw_en", DW'(cw_en), 0);
    chk(req_valid == 1'b0, "R1", "reset req_valid", DW'(req_valid), 0);
    load(16'h0010, 1'b0, '0, "R3");

    // R7: owned line, empty queue -> direct write
    store(16'h0010, 32'h1111_0010, 2'b11, 1'b1, 1'b0, 1'b0, "R7");

    // R1 miss, R3 forwarding with youngest entry
    store(16'h0020, 32'hA000_0001, 2'b00, 1'b0, 1'b1, 1'b1, "R1");
    load(16'h0020, 1'b1, 32'hA000_0001, "R3");
    store(16'h0020, 32'hA000_0002, 2'b00, 1'b0, 1'b1, 1'b1, "R1");
    load(16'h0020, 1'b1, 32'hA000_0002, "R3");
    idle(3); // R2: no write before the response
    expect_wr(16'h0020, 32'hA000_0001, "R2");
    expect_wr(16'h0020, 32'hA000_0002, "R2");
    respond(16'h0020);
    idle(3);
    chk(exp_q.size() == 0, "R2", "writes after response", exp_q.size(), 0);
    load(16'h0020, 1'b0, '0, "R3");

    // R7: untagged miss pending, owned store to other line passes it
    store(16'h0050, 32'h5050_5050, 2'b00, 1'b0, 1'b1, 1'b1, "R1");
    store(16'h0060, 32'h6060_6060, 2'b10, 1'b1, 1'b0, 1'b0, "R7");
    expect_wr(16'h0050, 32'h5050_5050, "R2");
    respond(16'h0050);
    idle(2);

    // R4/R5/R6: fence forces the owned store behind the shared one
    store(16'h0030, 32'h3030_3030, 2'b01, 1'b0, 1'b1, 1'b0, "R1");
    fence();
    st_valid = 1'b1; st_addr = 16'h0040; st_data = 32'h4040_4040; st_line_state = 2'b10;
    #2;
    chk(cw_en == 1'b0, "R5", "no direct write behind tag", DW'(cw_en), 0);
    chk(req_valid == 1'b0, "R5", "no request for owned line", DW'(req_valid), 0);
    @(posedge clk); #1;
    st_valid = 1'b0;
    load(16'h0040, 1'b1, 32'h4040_4040, "R4");
    idle(2);
    expect_wr(16'h0030, 32'h3030_3030, "R6");
    expect_wr(16'h0040, 32'h4040_4040, "R6");
    respond(16'h0030);
    idle(3);
    chk(exp_q.size() == 0, "R6", "ordered drain after fence", exp_q.size(), 0);

    // R9: fence on empty queue has no effect
    fence();
    store(16'h0070, 32'h7070_7070, 2'b10, 1'b1, 1'b0, 1'b0, "R9");

    // R8: fill, stall, out-of-order acks, R6 order
    for (int i = 0; i < DEPTH; i++)
      store(16'h0080 + AW'(i), 32'h8000_0000 + DW'(i), 2'b00, 1'b0, 1'b1, 1'b1, "R8");
    chk(st_ready == 1'b0, "R8", "full st_ready", DW'(st_ready), 0);
    st_valid = 1'b1; st_addr = 16'h0099; st_data = 32'h9999_9999; st_line_state = 2'b11;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(st_ready == 1'b0, "R8", "stalled st_ready", DW'(st_ready), 0);
      chk(req_valid == 1'b0, "R8", "stalled req_valid", DW'(req_valid), 0);
      chk(cw_en == 1'b0, "R8", "stalled cw_en", DW'(cw_en), 0);
      @(posedge clk); #1;
    end
    st_valid = 1'b0;
    for (int i = DEPTH - 1; i >= 1; i--) respond(16'h0080 + AW'(i));
    chk(st_ready == 1'b0, "R6", "head blocks acked entries", DW'(st_ready), 0);
    for (int i = 0; i < DEPTH; i++) expect_wr(16'h0080 + AW'(i), 32'h8000_0000 + DW'(i), "R6");
    respond(16'h0080);
    @(posedge clk); #1;
    chk(st_ready == 1'b1, "R8", "ready after drain", DW'(st_ready), 1);
    idle(10);
    chk(exp_q.size() == 0, "R6", "full drain complete", exp_q.size(), 0);
    chk(st_ready == 1'b1, "R8", "empty st_ready", DW'(st_ready), 1);

    finish_run();
  end
endmodule